// File: doc/BRIEF.md
# Lock-Step Classifier Cascade Sequencer

This block evaluates a staged classifier cascade on several image windows at once. A single controller walks the cascade memory from address zero. Every word it reads is presented to all lanes in the same cycle, so one stream of words drives the whole array the way a shared instruction stream drives a vector unit. Each lane owns one window. A feature-response unit outside this block supplies that lane's response to the feature currently being addressed.

A lane keeps a signed running sum over the features of the current stage. At each stage boundary the lane either survives or drops out. A lane that drops out freezes its state for the rest of the window. The controller stops early when no lane survives. Otherwise it runs to the end-of-cascade marker and then writes one location record per surviving lane into a downstream result FIFO, lowest lane first. It waits whenever the FIFO reports full. A new group of windows is accepted only after the whole group has finished.

Top module: `cas_seq_top`

## Requirements
- R1: A start pulse is accepted only while busy is low. A start raised during a run does not restart it and does not change its timing or its results.
- R2: On an accepted start, casAddr becomes 0 in the next cycle. It then advances by exactly one per consumed feature word or stage-end word and never skips.
- R3: Cascade words use bits [41:40] as the kind: 0 is a feature, 1 is a stage end, and 2 or 3 marks the end of the cascade. A feature word holds a signed threshold in [39:24], a signed pass value in [23:12] and a signed fail value in [11:0]. For each feature word, a surviving lane adds the pass value to its accumulator when its signed response is greater than or equal to the threshold, and adds the fail value otherwise.
- R4: A stage-end word holds a signed threshold in [39:24]. A lane survives the stage when its accumulator is greater than or equal to that threshold, equality included. The accumulator is then cleared, so every stage starts from zero.
- R5: laneAlive goes all ones on an accepted start. A lane that fails a stage holds its state, and no laneAlive bit rises again during the run.
- R6: When no lane survives a stage end at word index k, the run ends without reading further words. busy stays high for exactly k+3 cycles, and no record is written.
- R7: A window is detected only when its lane survives every stage up to the end marker at index m. Records {winScale[3:0], y[8:0], x[8:0]} are written one per detected lane in ascending lane order. With the FIFO never full, busy stays high for m+NL+2 cycles.
- R8: resValid is never high while resFull is high. A record held back by a full FIFO is written once space appears, so no record is lost.
- R9: After reset, busy, resValid, winDone and laneAlive are all zero and casAddr is 0. winDone is a one-cycle pulse in the last busy cycle, and the block is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | All window buffers are loaded; begin the run |
| winX | input | NL*COORD_W | x position of each lane's window |
| winY | input | NL*COORD_W | y position of each lane's window |
| winScale | input | SCALE_W | Scale index shared by the group |
| casAddr | output | ADDR_W | Cascade memory address |
| casData | input | WORD_W | Cascade word at casAddr (combinational read) |
| featResp | input | NL*FEAT_W | Per-lane signed response to the addressed feature |
| laneAlive | output | NL | Lanes still in the cascade |
| busy | output | 1 | A run is in progress |
| winDone | output | 1 | Pulse in the final cycle of a run |
| resValid | output | 1 | Write strobe to the result FIFO |
| resData | output | SCALE_W+2*COORD_W | Detection record |
| resFull | input | 1 | Result FIFO cannot accept a write |

## Verification
Directed groups separate the three ways a run can end. In the first, every lane passes, which exercises the emit order. In the second, every lane fails the first stage, which shows the early exit through the busy cycle count. In the third, an accumulator lands exactly on the stage threshold, which tells an inclusive comparison from a strict one. Random cascades with mixed per-lane responses give groups where some lanes pass and others fail at different stages. These show that dropped lanes stay frozen while the rest keep going. Random FIFO-full patterns separate stalling from dropping, and a start raised mid-run shows whether the run restarts.

// File: rtl/cas_seq_pkg.sv
package cas_seq_pkg;
  typedef enum logic [1:0] {
    K_FEAT  = 2'd0,
    K_STAGE = 2'd1,
    K_END   = 2'd2,
    K_END2  = 2'd3
  } kind_e;

  typedef struct packed {
    logic clrAll;
    logic featEn;
    logic stageEn;
  } strobe_t;
endpackage

// File: rtl/cas_seq_ctrl.sv
module cas_seq_ctrl
  import cas_seq_pkg::*;
#(
  parameter int NL     = 4,
  parameter int ADDR_W = 8,
  parameter int LIDX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  kind_e             wordKind,
  input  logic [NL-1:0]     alive,
  input  logic              resFull,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] casAddr,
  output logic [LIDX_W-1:0] emitIdx,
  output logic              busy,
  output logic              winDone,
  output logic              resValid
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_EMIT, S_FIN} state_e;
  state_e state, nxt;
  logic   advance;
  logic   consume;

  // One emit step per lane; a surviving lane waits for FIFO space.
  assign advance  = (state == S_EMIT) && (!alive[emitIdx] || !resFull);
  assign resValid = (state == S_EMIT) && alive[emitIdx] && !resFull;
  assign busy     = (state != S_IDLE);
  assign winDone  = (state == S_FIN);
  assign consume  = stb.featEn || stb.stageEn;

  always_comb begin
    stb = '0;
    nxt = state;
    case (state)
      S_IDLE: if (start) begin
        stb.clrAll = 1'b1;
        nxt        = S_RUN;
      end
      S_RUN: begin
        if (alive == '0) nxt = S_FIN;
        else begin
          case (wordKind)
            K_FEAT:  stb.featEn  = 1'b1;
            K_STAGE: stb.stageEn = 1'b1;
            default: nxt         = S_EMIT;
          endcase
        end
      end
      S_EMIT: if (advance && (emitIdx == LIDX_W'(NL - 1))) nxt = S_FIN;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      casAddr <= '0;
      emitIdx <= '0;
    end else begin
      state <= nxt;
      if (stb.clrAll) casAddr <= '0;
      else if (consume) casAddr <= casAddr + 1'b1;
      if (state == S_RUN) emitIdx <= '0;
      else if (advance) emitIdx <= emitIdx + 1'b1;
    end
  end
endmodule

// File: rtl/cas_seq_dp.sv
module cas_seq_dp
  import cas_seq_pkg::*;
#(
  parameter int NL      = 4,
  parameter int FEAT_W  = 16,
  parameter int VAL_W   = 12,
  parameter int ACC_W   = 20,
  parameter int COORD_W = 9,
  parameter int SCALE_W = 4,
  parameter int LIDX_W  = 2,
  localparam int WORD_W = 2 + FEAT_W + 2 * VAL_W,
  localparam int REC_W  = SCALE_W + 2 * COORD_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [WORD_W-1:0]     word,
  input  logic [NL*FEAT_W-1:0]  featResp,
  input  logic [NL*COORD_W-1:0] winX,
  input  logic [NL*COORD_W-1:0] winY,
  input  logic [SCALE_W-1:0]    winScale,
  input  logic [LIDX_W-1:0]     emitIdx,
  output logic [NL-1:0]         alive,
  output logic [REC_W-1:0]      record
);
  logic signed [FEAT_W-1:0] thr;
  logic        [VAL_W-1:0]  passV, failV;
  logic signed [ACC_W-1:0]  thrExt, passExt, failExt;

  assign thr     = $signed(word[WORD_W-3 -: FEAT_W]);
  assign passV   = word[2*VAL_W-1 -: VAL_W];
  assign failV   = word[VAL_W-1:0];
  assign thrExt  = {{(ACC_W-FEAT_W){thr[FEAT_W-1]}}, thr};
  assign passExt = {{(ACC_W-VAL_W){passV[VAL_W-1]}}, passV};
  assign failExt = {{(ACC_W-VAL_W){failV[VAL_W-1]}}, failV};

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic signed [ACC_W-1:0]  acc;
    logic signed [FEAT_W-1:0] resp;
    assign resp = $signed(featResp[l*FEAT_W +: FEAT_W]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc      <= '0;
        alive[l] <= 1'b0;
      end else if (stb.clrAll) begin
        acc      <= '0;
        alive[l] <= 1'b1;
      end else if (alive[l]) begin
        if (stb.featEn) acc <= acc + ((resp >= thr) ? passExt : failExt);
        if (stb.stageEn) begin
          alive[l] <= (acc >= thrExt);
          acc      <= '0;
        end
      end
    end
  end

  assign record = {winScale, winY[emitIdx*COORD_W +: COORD_W], winX[emitIdx*COORD_W +: COORD_W]};
endmodule

// File: rtl/cas_seq_top.sv
module cas_seq_top
  import cas_seq_pkg::*;
#(
  parameter int NL       = 4,
  parameter int FEAT_W   = 16,
  parameter int VAL_W    = 12,
  parameter int ACC_W    = 20,
  parameter int ADDR_W   = 8,
  parameter int COORD_W  = 9,
  parameter int SCALE_W  = 4,
  localparam int WORD_W  = 2 + FEAT_W + 2 * VAL_W,
  localparam int REC_W   = SCALE_W + 2 * COORD_W,
  localparam int LIDX_W  = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [NL*COORD_W-1:0] winX,
  input  logic [NL*COORD_W-1:0] winY,
  input  logic [SCALE_W-1:0]    winScale,
  output logic [ADDR_W-1:0]     casAddr,
  input  logic [WORD_W-1:0]     casData,
  input  logic [NL*FEAT_W-1:0]  featResp,
  output logic [NL-1:0]         laneAlive,
  output logic                  busy,
  output logic                  winDone,
  output logic                  resValid,
  output logic [REC_W-1:0]      resData,
  input  logic                  resFull
);
  strobe_t           stb;
  logic [LIDX_W-1:0] emitIdx;
  kind_e             wordKind;

  assign wordKind = kind_e'(casData[WORD_W-1 -: 2]);

  cas_seq_ctrl #(.NL(NL), .ADDR_W(ADDR_W), .LIDX_W(LIDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wordKind(wordKind),
    .alive(laneAlive), .resFull(resFull), .stb(stb), .casAddr(casAddr),
    .emitIdx(emitIdx), .busy(busy), .winDone(winDone), .resValid(resValid)
  );

  cas_seq_dp #(
    .NL(NL), .FEAT_W(FEAT_W), .VAL_W(VAL_W), .ACC_W(ACC_W),
    .COORD_W(COORD_W), .SCALE_W(SCALE_W), .LIDX_W(LIDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .word(casData), .featResp(featResp),
    .winX(winX), .winY(winY), .winScale(winScale), .emitIdx(emitIdx),
    .alive(laneAlive), .record(resData)
  );
endmodule

// File: rtl/cas_seq_chk.sv
module cas_seq_chk #(
  parameter int NL     = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] casAddr,
  input logic [NL-1:0]     laneAlive,
  input logic              busy,
  input logic              winDone,
  input logic              resValid,
  input logic              resFull
);
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !resFull); // R8
  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> busy); // R7
  AST_ADDR_FROM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (casAddr == '0)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (casAddr == $past(casAddr) || casAddr == $past(casAddr) + 1'b1)); // R2
  AST_ALIVE_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ((laneAlive & ~$past(laneAlive)) == '0)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    winDone |=> (!busy && !winDone)); // R9
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !winDone && start) |=> busy); // R1
endmodule

bind cas_seq_top cas_seq_chk #(.NL(NL), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .casAddr(casAddr),
  .laneAlive(laneAlive), .busy(busy), .winDone(winDone),
  .resValid(resValid), .resFull(resFull)
);

// File: tb/sim_cas_seq_top.sv
module sim_cas_seq_top;
  localparam int CLK_P = 10;
  localparam int NL = 4;
  localparam int MEMD = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [35:0] winX = '0, winY = '0;
  logic [3:0]  winScale = '0;
  logic [7:0]  casAddr;
  logic [41:0] casData;
  logic [63:0] featResp;
  logic [3:0]  laneAlive;
  logic        busy, winDone, resValid, resFull = 1'b0;
  logic [21:0] resData;

  logic [41:0]        casMem [MEMD];
  logic signed [15:0] respTab [NL][MEMD];

  int errors = 0, checks = 0, cycles = 0;

  cas_seq_top u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  assign casData = casMem[casAddr[5:0]];
  always_comb
    for (int l = 0; l < NL; l++) featResp[l*16 +: 16] = respTab[l][casAddr[5:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [41:0] mkFeat(int thr, int p, int f);
    logic [15:0] t = 16'(thr);
    logic [11:0] pv = 12'(p);
    logic [11:0] fv = 12'(f);
    return {2'd0, t, pv, fv};
  endfunction
  function automatic logic [41:0] mkStage(int thr);
    logic [15:0] t = 16'(thr);
    return {2'd1, t, 24'd0};
  endfunction

  // Reference model of the cascade, written from the requirements.
  task automatic model(output logic [3:0] passed, output int expCyc);
    int acc [NL];
    logic [3:0] al = 4'hF;
    for (int l = 0; l < NL; l++) acc[l] = 0;
    for (int i = 0; i < MEMD; i++) begin
      logic [41:0] w = casMem[i];
      if (w[41:40] == 2'd0) begin
        for (int l = 0; l < NL; l++)
          if (al[l])
            acc[l] += (respTab[l][i] >= $signed(w[39:24])) ? int'($signed(w[23:12])) : int'($signed(w[11:0]));
      end else if (w[41:40] == 2'd1) begin
        for (int l = 0; l < NL; l++) begin
          if (al[l] && acc[l] < int'($signed(w[39:24]))) al[l] = 1'b0;
          acc[l] = 0;
        end
        if (al == 0) begin passed = 0; expCyc = i + 3; return; end
      end else begin
        passed = al; expCyc = i + 1 + NL + 1; return;
      end
    end
    passed = 0; expCyc = -1;
  endtask

  task automatic randCascade();
    int a = 0;
    int ns = 1 + $urandom % 4;
    for (int s = 0; s < ns; s++) begin
      int nf = 1 + $urandom % 4;
      for (int f = 0; f < nf; f++) begin
        casMem[a] = mkFeat(int'($urandom % 17) - 8, int'($urandom % 16) - 5, int'($urandom % 16) - 10);
        a++;
      end
      casMem[a] = mkStage(int'($urandom % 13) - 6);
      a++;
    end
    casMem[a] = {2'd2, 40'd0};
    for (int l = 0; l < NL; l++)
      for (int i = 0; i < MEMD; i++) respTab[l][i] = 16'(int'($urandom % 17) - 8);
  endtask

  task automatic runWin(input bit randFull, input bit poke, input string tag);
    logic [3:0] expPass;
    int expCyc, cyc, nDone, nRec;
    logic [21:0] recs [NL];
    logic [3:0] prevAlive;
    int e;
    model(expPass, expCyc);
    winScale = 4'($urandom);
    winX = {$urandom, $urandom};
    winY = {$urandom, $urandom};
    @(negedge clk); start = 1'b1; resFull = 1'b0;
    @(negedge clk); start = 1'b0;
    #1;
    chk(casAddr == 0, {"R2 addr zero ", tag}, casAddr, 0);
    chk(laneAlive == 4'hF, {"R5 alive on start ", tag}, laneAlive, 15);
    cyc = 0; nDone = 0; nRec = 0; prevAlive = laneAlive;
    while (busy) begin
      cyc++;
      if ((laneAlive & ~prevAlive) != 0)
        chk(1'b0, {"R5 alive rose ", tag}, laneAlive, prevAlive);
      prevAlive = laneAlive;
      if (resValid) begin
        if (resFull) chk(1'b0, {"R8 write while full ", tag}, 1, 0);
        if (nRec < NL) recs[nRec] = resData;
        nRec++;
      end
      if (winDone) nDone++;
      @(negedge clk);
      resFull = randFull ? ($urandom % 3 == 0) : 1'b0;
      start = poke && (cyc == 2);
      #1;
    end
    start = 1'b0;
    chk(nDone == 1, {"R9 one done pulse ", tag}, nDone, 1);
    if (!randFull) chk(cyc == expCyc, {"R6/R7 busy cycles ", tag}, cyc, expCyc);
    chk(nRec == $countones(expPass), {"R7/R8 record count ", tag}, nRec, $countones(expPass));
    e = 0;
    for (int l = 0; l < NL; l++)
      if (expPass[l]) begin
        logic [21:0] want = {winScale, winY[l*9 +: 9], winX[l*9 +: 9]};
        if (e < nRec && e < NL)
          chk(recs[e] == want, {"R7 record order ", tag}, recs[e], want);
        e++;
      end
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < MEMD; i++) begin
      casMem[i] = {2'd2, 40'd0};
      for (int l = 0; l < NL; l++) respTab[l][i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !resValid && !winDone, "R9 reset idle", busy, 0);
    chk(casAddr == 0 && laneAlive == 0, "R9 reset addr/alive", casAddr, 0);
    rstN = 1'b1;

    // R3 R7: all lanes pass; pass value when response meets threshold
    casMem[0] = mkFeat(2, 5, -5);
    casMem[1] = mkStage(5);
    casMem[2] = {2'd3, 40'd0};
    for (int l = 0; l < NL; l++) respTab[l][0] = 16'(2 + l);
    runWin(1'b0, 1'b0, "all pass");

    // R6: all fail at first stage end (index 1), busy = 4 cycles
    for (int l = 0; l < NL; l++) respTab[l][0] = -16'sd1;
    runWin(1'b0, 1'b0, "all fail");

    // R4: lanes 0,2 land exactly on threshold, lanes 1,3 one below
    casMem[0] = mkFeat(0, 3, 2);
    casMem[1] = mkStage(3);
    casMem[2] = mkFeat(0, 1, -1);
    casMem[3] = mkStage(0);
    casMem[4] = {2'd2, 40'd0};
    respTab[0][0] = 0; respTab[1][0] = -1; respTab[2][0] = 5; respTab[3][0] = -3;
    for (int l = 0; l < NL; l++) respTab[l][2] = 16'(l == 1 ? -2 : 4);
    runWin(1'b0, 1'b0, "threshold equal");

    // R8: same cascade, FIFO full at random
    runWin(1'b1, 1'b0, "stall");

    // R1: start raised mid-run has no effect
    runWin(1'b0, 1'b1, "restart ignored");

    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < MEMD; i++) casMem[i] = {2'd2, 40'd0};
      randCascade();
      runWin(t % 3 == 2, t % 5 == 4, $sformatf("random %0d", t));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule